// File: doc/BRIEF.md
# Bus Write Issue Controller

This block is the processor-side sequencer that places write transactions on a shared address/data bus with a companion command bus. A requester hands it one write at a time through a valid/ready handshake: either a single write with one data word, or a block write with four data words. The controller then drives an address cycle carrying a write command, followed by the data cycles. It drives an active-low valid strobe on every cycle that carries an address or a data word.

The external agent throttles the controller through an active-low write-ready input. A 2-bit mode input selects how that input is honoured and how closely writes follow one another. In the legacy mode a write starts at most once every four bus cycles. In the pipelined mode the next address follows the previous final data word directly, and one more write can slip out after write-ready drops. In the reissue mode an address cycle that meets write-ready deasserted is abandoned and driven again once the agent is ready. A 4-bit pattern code sets the idle cycles between the data words of a block write.

Top module: `wr_issue_ctl`

## Requirements
- R1: At most one write is in flight. `req_ready` is high only while the bus is idle or while the final data word of the current write is on the bus. A request accepted at a clock edge has its address cycle on the bus in the very next cycle.
- R2: An address cycle drives `vout_n` low, the request address zero-extended onto `bus_ad`, and `bus_cmd` = 3'b100 for a single write or 3'b101 for a block write. An idle cycle drives `vout_n` high, `bus_cmd` = 3'b000 and `bus_ad` = 0.
- R3: A single write has one data cycle, right after its address cycle, carrying `req_data[DW-1:0]` with `bus_cmd` = 3'b011. A block write has NBEATS data cycles carrying lanes `req_data[i*DW +: DW]` in increasing order of i. The last of these is tagged 3'b011 and the others 3'b010. Data cycles drive `vout_n` low.
- R4: The first data word follows the address cycle directly. The idle cycles inserted after block word i (0-based, not after the last word) are set by `pattern`. Codes 1, 2, 4, 5 and 7 insert 1, 2, 3, 4 and 6 idle cycles respectively after each odd-numbered word. Codes 3, 6 and 8 insert 1, 2 and 3 idle cycles respectively after every word. Code 0 and codes 9 to 15 insert none.
- R5: Modes 2'b00 and 2'b01 are the legacy mode. A request is accepted only while `wr_rdy_n` is low. At least two idle cycles separate a final data word from the next address cycle, so back-to-back single writes start every four cycles.
- R6: In mode 2'b10 (pipelined), a queued request is accepted during the final data word, so its address follows immediately. Back-to-back single writes start every two cycles, and back-to-back block writes with code 0 start every five cycles.
- R7: In mode 2'b10, an address cycle that sees `wr_rdy_n` high still completes its data. After it, no request is accepted until `wr_rdy_n` is low.
- R8: In mode 2'b11 (reissue), an address cycle that sees `wr_rdy_n` high is abandoned: no data follows, the bus goes idle and no new request is accepted. In the cycle after an idle cycle in which `wr_rdy_n` is low, the same address is driven again and the write then completes with its original data and spacing.
- R9: In mode 2'b11 with `wr_rdy_n` low, writes follow each other as in the pipelined mode (singles every two cycles).
- R10: During and right after reset the bus is idle (`vout_n` high, `bus_cmd` 3'b000, `bus_ad` 0), and `req_ready` is high in legacy mode while `wr_rdy_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Controller accepts the offered request this cycle |
| req_block | input | 1 | 1 = block write, 0 = single write |
| req_addr | input | AW | Write address |
| req_data | input | NBEATS*DW | Data words, word i in lane i |
| wmode | input | 2 | Write mode: 00/01 legacy, 10 pipelined, 11 reissue |
| pattern | input | 4 | Block data spacing code |
| wr_rdy_n | input | 1 | Active-low write-ready from the external agent |
| bus_ad | output | DW | Multiplexed address/data bus |
| bus_cmd | output | 3 | Command/tag for the current bus cycle |
| vout_n | output | 1 | Active-low valid strobe for address or data cycles |

## Verification
The bench builds the controller with a 16-bit bus, 12-bit addresses and four words per block. With narrow lanes, every word can carry a distinct, arithmetically derived value, and block writes stay short. That makes it cheap to sweep all sixteen pattern codes under the legacy, pipelined and reissue modes, and to check the gap before every word against the spacing table. Throttling by write-ready is exercised in each mode: the legacy stall, the one extra pipelined write, and an abandoned-then-reissued single and block write.

// File: rtl/wr_issue_ctl.sv
module wr_issue_ctl #(
  parameter int DW = 64,
  parameter int AW = 36,
  parameter int NBEATS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_block,
  input  logic [AW-1:0]        req_addr,
  input  logic [NBEATS*DW-1:0] req_data,
  input  logic [1:0]           wmode,
  input  logic [3:0]           pattern,
  input  logic                 wr_rdy_n,
  output logic [DW-1:0]        bus_ad,
  output logic [2:0]           bus_cmd,
  output logic                 vout_n
);
  localparam int BW = (NBEATS > 1) ? $clog2(NBEATS) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(NBEATS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_BEAT, S_GAP, S_RETRY} st_t;

  st_t st;
  logic [AW-1:0]        a_q;
  logic [NBEATS*DW-1:0] d_q;
  logic                 blk_q;
  logic [1:0]           m_q;
  logic [3:0]           p_q;
  logic [BW-1:0]        idx;
  logic [2:0]           gcnt;
  logic                 cool;
  logic                 over;
  logic [DW-1:0]        lanes [NBEATS];

  for (genvar i = 0; i < NBEATS; i++) begin : g_lane
    assign lanes[i] = d_q[i*DW +: DW];
  end

  function automatic logic [2:0] gap_after(input logic [3:0] p, input logic odd);
    logic [2:0] k;
    logic       every;
    k = 3'd0;
    every = 1'b0;
    case (p)
      4'd1: k = 3'd1;
      4'd2: k = 3'd2;
      4'd4: k = 3'd3;
      4'd5: k = 3'd4;
      4'd7: k = 3'd6;
      4'd3: begin k = 3'd1; every = 1'b1; end
      4'd6: begin k = 3'd2; every = 1'b1; end
      4'd8: begin k = 3'd3; every = 1'b1; end
      default: k = 3'd0;
    endcase
    return (every || odd) ? k : 3'd0;
  endfunction

  logic       last_beat;
  logic       gate;
  logic       take;
  logic       abort;
  logic [2:0] gnow;

  assign last_beat = (st == S_BEAT) && (!blk_q || idx == LAST_IDX);
  assign gate = !wmode[1] ? !wr_rdy_n :
                (wmode == 2'b10) ? (!over || !wr_rdy_n) : 1'b1;
  assign req_ready = gate && ((st == S_IDLE && !cool) || (last_beat && m_q[1]));
  assign take  = req_valid && req_ready;
  assign abort = (st == S_ADDR) && (m_q == 2'b11) && wr_rdy_n;
  assign gnow  = gap_after(p_q, idx[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      d_q   <= '0;
      blk_q <= 1'b0;
      m_q   <= 2'b00;
      p_q   <= 4'd0;
      idx   <= '0;
      gcnt  <= 3'd0;
      cool  <= 1'b0;
      over  <= 1'b0;
    end else begin
      if (take) begin
        a_q   <= req_addr;
        d_q   <= req_data;
        blk_q <= req_block;
        m_q   <= wmode;
        p_q   <= pattern;
      end
      if (st == S_ADDR) over <= wr_rdy_n;
      else if (!wr_rdy_n) over <= 1'b0;
      cool <= last_beat && !m_q[1];
      case (st)
        S_IDLE: if (take) st <= S_ADDR;
        S_ADDR: begin
          if (abort) st <= S_RETRY;
          else begin
            st  <= S_BEAT;
            idx <= '0;
          end
        end
        S_BEAT: begin
          if (last_beat) st <= take ? S_ADDR : S_IDLE;
          else if (gnow == 3'd0) idx <= idx + 1'b1;
          else begin
            st   <= S_GAP;
            gcnt <= gnow - 3'd1;
          end
        end
        S_GAP: begin
          if (gcnt == 3'd0) begin
            st  <= S_BEAT;
            idx <= idx + 1'b1;
          end else gcnt <= gcnt - 3'd1;
        end
        S_RETRY: if (!wr_rdy_n) st <= S_ADDR;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_ad  = '0;
    bus_cmd = 3'b000;
    if (st == S_ADDR) begin
      bus_ad  = DW'(a_q);
      bus_cmd = {2'b10, blk_q};
    end else if (st == S_BEAT) begin
      bus_ad  = lanes[idx];
      bus_cmd = {2'b01, last_beat};
    end
  end

  assign vout_n = !(st == S_ADDR || st == S_BEAT);

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (vout_n || bus_cmd == 3'b011));

  // R1
  accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_cmd[2] && !vout_n));

  // R3
  single_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 3'b100 && !wr_rdy_n) |=> (bus_cmd == 3'b011 && !vout_n));

  // R5
  legacy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 3'b011 && !m_q[1]) |=> vout_n ##1 vout_n);

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd[2] && m_q == 2'b11 && wr_rdy_n) |=> (vout_n && !req_ready));
endmodule

// File: tb/wr_issue_ctl_test.sv
`timescale 1ns/1ps
module wr_issue_ctl_test;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int NB = 4;
  localparam int MAXEV = 8192;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_block;
  logic [AW-1:0] req_addr;
  logic [NB*DW-1:0] req_data;
  logic [1:0] wmode;
  logic [3:0] pattern;
  logic wr_rdy_n;
  logic [DW-1:0] bus_ad;
  logic [2:0] bus_cmd;
  logic vout_n;

  wr_issue_ctl #(.DW(DW), .AW(AW), .NBEATS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .req_addr(req_addr), .req_data(req_data),
    .wmode(wmode), .pattern(pattern), .wr_rdy_n(wr_rdy_n),
    .bus_ad(bus_ad), .bus_cmd(bus_cmd), .vout_n(vout_n)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;
  int n_ev = 0;
  int ev_c [MAXEV];
  logic [2:0] ev_cmd [MAXEV];
  logic [DW-1:0] ev_ad [MAXEV];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n === 1'b1 && vout_n === 1'b0 && n_ev < MAXEV) begin
      ev_c[n_ev] = cyc;
      ev_cmd[n_ev] = bus_cmd;
      ev_ad[n_ev] = bus_ad;
      n_ev++;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane(input int seed, input int i);
    return DW'(16'h1100 * (i + 1) + seed);
  endfunction

  function automatic logic [NB*DW-1:0] mkdata(input int seed);
    logic [NB*DW-1:0] d;
    for (int i = 0; i < NB; i++) d[i*DW +: DW] = lane(seed, i);
    return d;
  endfunction

  function automatic int expgap(input int p, input int i);
    case (p)
      1: return (i % 2 == 1) ? 1 : 0;
      2: return (i % 2 == 1) ? 2 : 0;
      4: return (i % 2 == 1) ? 3 : 0;
      5: return (i % 2 == 1) ? 4 : 0;
      7: return (i % 2 == 1) ? 6 : 0;
      3: return 1;
      6: return 2;
      8: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic send(input bit blk, input logic [AW-1:0] a, input logic [NB*DW-1:0] d);
    req_block = blk; req_addr = a; req_data = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic verify_block(input int b, input logic [AW-1:0] a, input int seed, input int p, input string tag);
    chk(ev_cmd[b] == 3'b101, {"R2 block addr cmd ", tag}, ev_cmd[b], 3'b101);
    chk(ev_ad[b] == DW'(a), {"R2 block addr value ", tag}, ev_ad[b], a);
    for (int i = 0; i < NB; i++) begin
      chk(ev_cmd[b+1+i] == ((i == NB-1) ? 3'b011 : 3'b010), {"R3 beat tag ", tag}, ev_cmd[b+1+i], i);
      chk(ev_ad[b+1+i] == lane(seed, i), {"R3 beat data ", tag}, ev_ad[b+1+i], lane(seed, i));
    end
    chk(ev_c[b+1] == ev_c[b] + 1, {"R4 first beat follows addr ", tag}, ev_c[b+1] - ev_c[b], 1);
    for (int i = 1; i < NB; i++)
      chk(ev_c[b+1+i] - ev_c[b+i] == 1 + expgap(p, i-1), {"R4 beat spacing ", tag},
          ev_c[b+1+i] - ev_c[b+i], 1 + expgap(p, i-1));
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mark, seed, nrel, bad;
    logic [1:0] modes [3];
    rst_n = 1'b0; req_valid = 1'b0; req_block = 1'b0; req_addr = '0; req_data = '0;
    wmode = 2'b00; pattern = 4'd0; wr_rdy_n = 1'b0;
    idle(3);
    chk(vout_n == 1'b1 && bus_cmd == 3'b000 && bus_ad == '0, "R10 idle bus in reset", {vout_n, bus_cmd}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(vout_n == 1'b1 && bus_cmd == 3'b000, "R10 idle bus after reset", {vout_n, bus_cmd}, 4'b1000);
    @(negedge clk);

    // R4 R3 R2: every pattern code under three modes
    modes[0] = 2'b00; modes[1] = 2'b10; modes[2] = 2'b11;
    seed = 1;
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 16; p++) begin
        mark = n_ev;
        wmode = modes[m]; pattern = 4'(p);
        send(1'b1, AW'(12'h100 + seed), mkdata(seed));
        idle(30);
        chk(n_ev - mark == 1 + NB, "R3 block cycle count", n_ev - mark, 1 + NB);
        verify_block(mark, AW'(12'h100 + seed), seed, p, $sformatf("mode %0d pat %0d", modes[m], p));
        seed++;
      end

    // R5 R6 R9: back-to-back single writes in each mode
    for (int m = 0; m < 4; m++) begin
      int sp;
      sp = (m >= 2) ? 2 : 4;
      mark = n_ev;
      wmode = 2'(m); pattern = 4'd0;
      for (int k = 0; k < 4; k++) send(1'b0, AW'(12'h300 + 16*m + k), mkdata(40 + k));
      idle(12);
      chk(n_ev - mark == 8, $sformatf("R1 single count mode %0d", m), n_ev - mark, 8);
      for (int k = 0; k < 4; k++) begin
        chk(ev_cmd[mark+2*k] == 3'b100 && ev_ad[mark+2*k] == DW'(12'h300 + 16*m + k),
            "R2 single addr", ev_ad[mark+2*k], 12'h300 + 16*m + k);
        chk(ev_cmd[mark+2*k+1] == 3'b011 && ev_ad[mark+2*k+1] == lane(40 + k, 0),
            "R3 single data", ev_ad[mark+2*k+1], lane(40 + k, 0));
        if (k > 0)
          chk(ev_c[mark+2*k] - ev_c[mark+2*k-2] == sp,
              (m >= 2) ? ((m == 3) ? "R9 reissue spacing" : "R6 pipelined spacing") : "R5 legacy spacing",
              ev_c[mark+2*k] - ev_c[mark+2*k-2], sp);
      end
    end

    // R6: back-to-back block writes, pattern 0
    mark = n_ev; wmode = 2'b10; pattern = 4'd0;
    send(1'b1, AW'(12'h500), mkdata(60));
    send(1'b1, AW'(12'h501), mkdata(61));
    idle(14);
    chk(n_ev - mark == 10, "R6 two blocks", n_ev - mark, 10);
    chk(ev_c[mark+5] - ev_c[mark] == 5, "R6 block to block spacing", ev_c[mark+5] - ev_c[mark], 5);
    verify_block(mark + 5, AW'(12'h501), 61, 0, "second block");

    // R5: legacy stall while write-ready is high
    wmode = 2'b00; wr_rdy_n = 1'b1; mark = n_ev;
    req_block = 1'b0; req_addr = AW'(12'h600); req_data = mkdata(70); req_valid = 1'b1;
    bad = 0;
    for (int k = 0; k < 8; k++) begin #1; if (req_ready) bad++; @(negedge clk); end
    chk(bad == 0 && n_ev == mark, "R5 legacy holds off while not ready", bad + n_ev - mark, 0);
    req_valid = 1'b0;
    wr_rdy_n = 1'b0;
    send(1'b0, AW'(12'h600), mkdata(70));
    idle(6);
    chk(n_ev - mark == 2 && ev_ad[mark] == DW'(12'h600), "R5 legacy write after ready", ev_ad[mark], 12'h600);

    // R7: pipelined allows one extra write, then stalls
    wmode = 2'b10; wr_rdy_n = 1'b1; mark = n_ev;
    send(1'b0, AW'(12'h700), mkdata(80));
    req_block = 1'b0; req_addr = AW'(12'h701); req_data = mkdata(81); req_valid = 1'b1;
    bad = 0;
    for (int k = 0; k < 10; k++) begin #1; if (req_ready) bad++; @(negedge clk); end
    chk(n_ev - mark == 2, "R7 extra write completes", n_ev - mark, 2);
    chk(ev_cmd[mark+1] == 3'b011 && ev_ad[mark+1] == lane(80, 0), "R7 extra write data", ev_ad[mark+1], lane(80, 0));
    chk(bad == 0, "R7 stall after extra write", bad, 0);
    nrel = cyc;
    wr_rdy_n = 1'b0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 1'b0;
    idle(4);
    chk(n_ev - mark == 4 && ev_ad[mark+2] == DW'(12'h701), "R7 resume after ready", ev_ad[mark+2], 12'h701);
    chk(ev_c[mark+2] == nrel + 1, "R7 resume timing", ev_c[mark+2], nrel + 1);

    // R8: reissue of an abandoned single write
    wmode = 2'b11; wr_rdy_n = 1'b1; mark = n_ev;
    send(1'b0, AW'(12'h800), mkdata(90));
    bad = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); #1; if (req_ready) bad++; end
    chk(n_ev - mark == 1 && ev_cmd[mark] == 3'b100, "R8 abort leaves only address", n_ev - mark, 1);
    chk(bad == 0, "R8 no accept while held", bad, 0);
    @(negedge clk);
    nrel = cyc;
    wr_rdy_n = 1'b0;
    idle(5);
    chk(n_ev - mark == 3, "R8 reissue cycle count", n_ev - mark, 3);
    chk(ev_cmd[mark+1] == 3'b100 && ev_ad[mark+1] == DW'(12'h800), "R8 same address reissued", ev_ad[mark+1], 12'h800);
    chk(ev_c[mark+1] == nrel + 1, "R8 reissue timing", ev_c[mark+1], nrel + 1);
    chk(ev_cmd[mark+2] == 3'b011 && ev_ad[mark+2] == lane(90, 0), "R8 reissued data", ev_ad[mark+2], lane(90, 0));

    // R8: reissue of an abandoned block write keeps spacing
    wr_rdy_n = 1'b1; pattern = 4'd3; mark = n_ev;
    send(1'b1, AW'(12'h900), mkdata(95));
    idle(5);
    chk(n_ev - mark == 1, "R8 block abort", n_ev - mark, 1);
    wr_rdy_n = 1'b0;
    idle(20);
    chk(n_ev - mark == 2 + NB, "R8 block reissue count", n_ev - mark, 2 + NB);
    verify_block(mark + 1, AW'(12'h900), 95, 3, "R8 reissued block");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule